// File: doc/BRIEF.md
# Fifteen-Cent Coin Vending Controller

This block is a synchronous Mealy controller that tallies credit from inserted coins and decides when an item is released. Each clock cycle it may receive a one-cycle pulse meaning a nickel (5 cents) or a dime (10 cents). Credit is kept in one of three states: zero, five or ten cents. When a coin brings the total to 15 cents or more, the block pulses a vend strobe in that same cycle and the credit goes back to zero. If the total reaches 20 cents, it also pulses a strobe that returns one nickel.

Outputs depend on both the current credit state and the coin input in the same cycle. A cycle with no coin leaves the credit unchanged. A cycle that shows both coin pulses at once is treated as a cycle with no coin.

Top module: `vend_ctrl_top`

## Requirements
- R1: While the synchronous active-high reset `rst` is high at a clock edge, the credit returns to zero cents (`credit_o` = 2'b00). During reset cycles `vend_o` and `change_o` are low.
- R2: At zero credit, a nickel moves the credit to 5 cents (2'b01) and a dime moves it to 10 cents (2'b10). Neither output is asserted.
- R3: At 5 cents, a nickel moves the credit to 10 cents and no output is asserted.
- R4: At 5 cents, a dime asserts `vend_o` in the same cycle with `change_o` low, and the credit returns to zero.
- R5: At 10 cents, a nickel asserts `vend_o` in the same cycle with `change_o` low, and the credit returns to zero.
- R6: At 10 cents, a dime asserts both `vend_o` and `change_o` in the same cycle, and the credit returns to zero.
- R7: A cycle with no coin keeps the credit unchanged and both outputs low.
- R8: A cycle with both `nickel_i` and `dime_i` high has no effect: the credit is unchanged and both outputs are low.
- R9: `change_o` is only ever high together with `vend_o`. Each strobe lasts only the cycle of the coin pulse that completes the purchase.
- R10: The credit encoding is 00 for 0 cents, 01 for 5 cents and 10 for 10 cents. If the state register holds 11, the block treats it as zero credit with no outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| nickel_i | input | 1 | One-cycle pulse: a 5-cent coin was inserted |
| dime_i | input | 1 | One-cycle pulse: a 10-cent coin was inserted |
| vend_o | output | 1 | Release one item (Mealy, same cycle as the coin) |
| change_o | output | 1 | Return one nickel (Mealy, same cycle as the coin) |
| credit_o | output | 2 | Current credit state code |

## Verification
The credit state is visible on `credit_o` as soon as the clock edge after a coin has passed. A wrong transition therefore shows up one cycle later as an unexpected code. It also shows up in the combinational response to the next coin: a premature vend, a missing vend, or a wrong change pulse. The bench drives every coin pattern (none, nickel, dime, both) from each reachable state. It checks the Mealy outputs in the cycle of the coin and the code after the edge, so a fault in any single transition is exposed within two cycles.

// File: rtl/vend_pkg.sv
package vend_pkg;
    localparam int unsigned CODE_W = 2;

    typedef enum logic [CODE_W-1:0] {
        CR_ZERO = 2'b00,
        CR_FIVE = 2'b01,
        CR_TEN  = 2'b10,
        CR_BAD  = 2'b11
    } credit_e;

    typedef enum logic [1:0] {
        COIN_NONE,
        COIN_NICKEL,
        COIN_DIME
    } coin_e;

    typedef struct packed {
        logic vend;
        logic change;
    } strobe_t;

    function automatic coin_e classify(input logic nk, input logic dm);
        if (nk && !dm) return COIN_NICKEL;
        if (dm && !nk) return COIN_DIME;
        return COIN_NONE;
    endfunction
endpackage

// File: rtl/vend_coin_decode.sv
module vend_coin_decode
    import vend_pkg::*;
(
    input  logic  nickel_i,
    input  logic  dime_i,
    output coin_e coin_o
);
    always_comb coin_o = classify(nickel_i, dime_i);
endmodule

// File: rtl/vend_next.sv
module vend_next
    import vend_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  credit_e cur_i,
    input  coin_e   coin_i,
    output credit_e nxt_o,
    output strobe_t out_o
);
    always_comb begin
        nxt_o = cur_i;
        out_o = '0;
        unique case (cur_i)
            CR_ZERO: begin
                if (coin_i == COIN_NICKEL) nxt_o = CR_FIVE;
                else if (coin_i == COIN_DIME) nxt_o = CR_TEN;
            end
            CR_FIVE: begin
                if (coin_i == COIN_NICKEL) nxt_o = CR_TEN;
                else if (coin_i == COIN_DIME) begin
                    nxt_o = CR_ZERO;
                    out_o.vend = 1'b1;
                end
            end
            CR_TEN: begin
                if (coin_i != COIN_NONE) begin
                    nxt_o = CR_ZERO;
                    out_o.vend = 1'b1;
                    out_o.change = (coin_i == COIN_DIME);
                end
            end
            default: nxt_o = CR_ZERO;
        endcase
    end

    // R9: change only with vend
    a_r9_change_needs_vend: assert property (@(posedge clk) disable iff (rst)
        out_o.change |-> out_o.vend);
    // R7: idle holds and stays quiet
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (coin_i == COIN_NONE && cur_i != CR_BAD) |-> (out_o == '0 && nxt_o == cur_i));
endmodule

// File: rtl/vend_state_reg.sv
module vend_state_reg
    import vend_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  credit_e nxt_i,
    output credit_e cur_o
);
    always_ff @(posedge clk) begin
        if (rst) cur_o <= CR_ZERO;
        else     cur_o <= nxt_i;
    end

    // R1: reset lands in zero credit
    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> cur_o == CR_ZERO);
endmodule

// File: rtl/vend_ctrl_top.sv
module vend_ctrl_top
    import vend_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       nickel_i,
    input  logic       dime_i,
    output logic       vend_o,
    output logic       change_o,
    output logic [1:0] credit_o
);
    coin_e   coin;
    credit_e cur, nxt;
    strobe_t stb;

    vend_coin_decode u_dec (.nickel_i(nickel_i), .dime_i(dime_i), .coin_o(coin));
    vend_next u_nxt (.clk(clk), .rst(rst), .cur_i(cur), .coin_i(coin), .nxt_o(nxt), .out_o(stb));
    vend_state_reg u_reg (.clk(clk), .rst(rst), .nxt_i(nxt), .cur_o(cur));

    assign vend_o   = stb.vend && !rst;
    assign change_o = stb.change && !rst;
    assign credit_o = cur;

    // R10: unused code never reached
    a_r10_no_bad_code: assert property (@(posedge clk) disable iff (rst)
        credit_o != 2'b11);
    // R6: dime at ten cents vends with change and clears
    a_r6_dime_at_ten: assert property (@(posedge clk) disable iff (rst)
        (credit_o == 2'b10 && dime_i && !nickel_i) |-> (vend_o && change_o) ##1 credit_o == 2'b00);
    // R8: both coins at once are ignored
    a_r8_both_ignored: assert property (@(posedge clk) disable iff (rst)
        (nickel_i && dime_i) |-> (!vend_o && !change_o) ##1 $stable(credit_o));
    // R4/R5: vend always clears credit
    a_r4_vend_clears: assert property (@(posedge clk) disable iff (rst)
        vend_o |=> credit_o == 2'b00);
endmodule

// File: tb/tb_vend_ctrl_top.sv
module tb_vend_ctrl_top;
    logic clk = 1'b0;
    logic rst, nickel_i, dime_i;
    logic vend_o, change_o;
    logic [1:0] credit_o;
    int checks = 0, errors = 0;
    bit done = 0;

    vend_ctrl_top dut (.clk(clk), .rst(rst), .nickel_i(nickel_i), .dime_i(dime_i),
                       .vend_o(vend_o), .change_o(change_o), .credit_o(credit_o));

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // drive coin pattern, check Mealy outputs mid-cycle, then credit after edge
    task automatic coin(input string req, input logic nk, input logic dm,
                        input logic ev, input logic ec, input logic [1:0] en);
        nickel_i = nk; dime_i = dm;
        #1;
        chk(req, {2'b00, vend_o, change_o}, {2'b00, ev, ec});
        @(posedge clk); #2;
        nickel_i = 0; dime_i = 0;
        chk(req, {2'b00, credit_o}, {2'b00, en});
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1; nickel_i = 0; dime_i = 0;
        @(posedge clk); #2;
        rst = 0;
        chk("R1", {2'b00, credit_o}, 4'b0000);
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk); rst = 1; nickel_i = 0; dime_i = 1;
        #1 chk("R1 out", {2'b00, vend_o, change_o}, 4'b0000);
        @(posedge clk); #2;
        chk("R1", {2'b00, credit_o}, 4'b0000);
        rst = 0; dime_i = 0;
        @(negedge clk);
    endtask

    task automatic t_from_zero();
        do_reset(); coin("R2 nickel", 1, 0, 0, 0, 2'b01);
        do_reset(); coin("R2 dime", 0, 1, 0, 0, 2'b10);
        do_reset(); coin("R7 idle0", 0, 0, 0, 0, 2'b00);
        do_reset(); coin("R8 both0", 1, 1, 0, 0, 2'b00);
    endtask

    task automatic t_from_five();
        do_reset(); coin("R2", 1, 0, 0, 0, 2'b01); @(negedge clk);
        coin("R7 idle5", 0, 0, 0, 0, 2'b01); @(negedge clk);
        coin("R8 both5", 1, 1, 0, 0, 2'b01); @(negedge clk);
        coin("R3", 1, 0, 0, 0, 2'b10);
        do_reset(); coin("R2", 1, 0, 0, 0, 2'b01); @(negedge clk);
        coin("R4", 0, 1, 1, 0, 2'b00); @(negedge clk);
        coin("R9 pulse", 0, 0, 0, 0, 2'b00);
    endtask

    task automatic t_from_ten();
        do_reset(); coin("R2", 0, 1, 0, 0, 2'b10); @(negedge clk);
        coin("R7 idle10", 0, 0, 0, 0, 2'b10); @(negedge clk);
        coin("R8 both10", 1, 1, 0, 0, 2'b10); @(negedge clk);
        coin("R5", 1, 0, 1, 0, 2'b00);
        do_reset(); coin("R2", 0, 1, 0, 0, 2'b10); @(negedge clk);
        coin("R6", 0, 1, 1, 1, 2'b00); @(negedge clk);
        coin("R9 pulse", 0, 0, 0, 0, 2'b00);
    endtask

    task automatic t_sequences();
        // nickel x3 then dime x2 back to back; R10 codes checked each step
        do_reset();
        coin("R10 n1", 1, 0, 0, 0, 2'b01);
        coin("R10 n2", 1, 0, 0, 0, 2'b10);
        coin("R5 n3", 1, 0, 1, 0, 2'b00);
        coin("R2 d1", 0, 1, 0, 0, 2'b10);
        coin("R6 d2", 0, 1, 1, 1, 2'b00);
    endtask

    initial begin
        rst = 1; nickel_i = 0; dime_i = 0;
        repeat (2) @(posedge clk);
        t_reset();
        t_from_zero();
        t_from_five();
        t_from_ten();
        t_sequences();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule